// File: doc/BRIEF.md
# Fifteen-Level Interrupt Controller

This block gathers interrupt events from the on-chip peripherals into one processor request. The peripherals are two serial channels, a serial overrun error, a periodic clock tick and a general-purpose timer tick. The request uses fifteen priority levels, numbered 1 to 15. Each event pulse sets a latched pending bit at a fixed level. Software can also raise any level directly through a force register, with no hardware source behind it. A mask register blocks levels from reaching the processor.

The controller drives a 4-bit request that names the highest unmasked level that is pending. The processor acknowledges a level by presenting its number with a strobe. This retires the level in both the pending set and the force set.

Software reaches four registers through a small register bus. The bus has a 2-bit register index, write and read strobes, and write data. Read data is registered and is qualified by a valid flag one cycle after the read strobe. There are no external interrupt pins and no edge or level shape setting.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, pending and force read 0x0000, mask reads 0xFFFE (every level masked) and the request output is 0.
- R2: Register index 0 is pending and is read-only, so writes to it are ignored. Index 1 is mask (read/write). Index 2 is clear: it is write-only and reads 0x0000. Index 3 is force (read/write). In every register, bit n stands for level n. Bit 0 always reads 0, and writes to bit 0 are dropped.
- R3: Event pulses set their pending bit on the following clock edge, at these levels: serial channel A at level 4, serial channel B at level 5, serial overrun at level 3, general-purpose timer at level 12 and periodic clock at level 13.
- R4: Writing 1 to a bit of the clear register clears that pending bit. Writing 0 to a bit leaves that bit unchanged.
- R5: Any level from 1 to 15 can be raised by writing its force bit. A level counts as pending while either its pending bit or its force bit is set.
- R6: A mask bit of 1 keeps its level out of the request.
- R7: The request output is the highest-numbered unmasked level that is pending, with level 15 highest. It is 0 when no such level exists.
- R8: An acknowledge of level N clears pending bit N and force bit N on the same clock edge. Other bits are left unchanged.
- R9: An event pulse arriving in the same cycle as a clear or an acknowledge of its level wins, so the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regIdx | input | 2 | Register index: 0 pending, 1 mask, 2 clear, 3 force |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data, bit n = level n |
| rdEn | input | 1 | Register read strobe |
| rdData | output | 16 | Registered read data |
| rdValid | output | 1 | rdData holds the result of the read issued the cycle before |
| uartAEvt | input | 1 | Serial channel A character event pulse |
| uartBEvt | input | 1 | Serial channel B character event pulse |
| uartOvfEvt | input | 1 | Serial receive overrun pulse |
| gptTick | input | 1 | General-purpose timer tick pulse |
| rtcTick | input | 1 | Periodic clock tick pulse |
| irqLevel | output | 4 | Requested level, 0 when none |
| ackValid | input | 1 | Acknowledge strobe |
| ackLevel | input | 4 | Level being acknowledged |

## Verification
The bench builds the block with its default parameters: fifteen levels, a 16-bit data path, and the level assignments above. With this build, every level can be reached through the force register. The cases covered include levels that no source drives, including level 1 at the very bottom of the priority order. The five event inputs land on their fixed bits. This makes it possible to check simultaneous sources, and races where a pulse meets a clear or an acknowledge of the same level.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned REG_IDX_W = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_PEND  = 2'd0,
    REG_MASK  = 2'd1,
    REG_CLR   = 2'd2,
    REG_FORCE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrMask;
    logic    wrClear;
    logic    wrForce;
    logic    rdStrobe;
    regSel_e rdSel;
    logic    ackStrobe;
  } ctlStrobe_t;
endpackage

// File: rtl/lvl_irq_ctl.sv
module lvl_irq_ctl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 15,
  parameter int unsigned LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic                 ackValid,
  input  logic [LVL_W-1:0]     ackLevel,
  output ctlStrobe_t           strobes
);
  regSel_e sel;

  always_comb begin
    sel               = regSel_e'(regIdx);
    strobes           = '0;
    strobes.wrMask    = wrEn && (sel == REG_MASK);
    strobes.wrClear   = wrEn && (sel == REG_CLR);
    strobes.wrForce   = wrEn && (sel == REG_FORCE);
    strobes.rdStrobe  = rdEn;
    strobes.rdSel     = sel;
    // out-of-range or level-0 acknowledges are dropped
    strobes.ackStrobe = ackValid && (ackLevel != '0) &&
                        (32'(ackLevel) <= NUM_LEVELS);
  end

  // R2: a single write targets at most one register
  assert_one_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrMask, strobes.wrClear, strobes.wrForce}));

  // R8: a retire strobe only follows a real acknowledge
  assert_ack_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ackStrobe |-> ackValid);
endmodule

// File: rtl/lvl_irq_dp.sv
module lvl_irq_dp
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_LEVELS   = 15,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned LVL_W        = $clog2(NUM_LEVELS + 1),
  parameter int unsigned UART_A_LVL   = 4,
  parameter int unsigned UART_B_LVL   = 5,
  parameter int unsigned UART_ERR_LVL = 3,
  parameter int unsigned GPT_LVL      = 12,
  parameter int unsigned RTC_LVL      = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LVL_W-1:0]  ackLevel,
  input  logic              uartAEvt,
  input  logic              uartBEvt,
  input  logic              uartOvfEvt,
  input  logic              gptTick,
  input  logic              rtcTick,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [LVL_W-1:0]  irqLevel
);
  localparam int unsigned VEC_W   = NUM_LEVELS + 1;
  localparam logic [VEC_W-1:0] LVL_ONLY = ~VEC_W'(1);

  logic [VEC_W-1:0] pendQ, forceQ, maskQ;
  logic [VEC_W-1:0] srcVec, ackVec, clrVec, wrBits, effVec;

  always_comb begin
    srcVec               = '0;
    srcVec[UART_A_LVL]   = srcVec[UART_A_LVL]   | uartAEvt;
    srcVec[UART_B_LVL]   = srcVec[UART_B_LVL]   | uartBEvt;
    srcVec[UART_ERR_LVL] = srcVec[UART_ERR_LVL] | uartOvfEvt;
    srcVec[GPT_LVL]      = srcVec[GPT_LVL]      | gptTick;
    srcVec[RTC_LVL]      = srcVec[RTC_LVL]      | rtcTick;
    srcVec               = srcVec & LVL_ONLY;
  end

  assign wrBits = wrData[VEC_W-1:0] & LVL_ONLY;
  assign clrVec = strobes.wrClear ? wrBits : '0;
  assign ackVec = strobes.ackStrobe ? (VEC_W'(1) << ackLevel) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= '0;
      forceQ <= '0;
      maskQ  <= LVL_ONLY;
    end else begin
      pendQ <= (pendQ & ~clrVec & ~ackVec) | srcVec;
      if (strobes.wrForce) forceQ <= wrBits;
      else                 forceQ <= forceQ & ~ackVec;
      if (strobes.wrMask)  maskQ  <= wrBits;
    end
  end

  assign effVec = (pendQ | forceQ) & ~maskQ;

  always_comb begin
    irqLevel = '0;
    for (int i = 1; i < VEC_W; i++) begin
      if (effVec[i]) irqLevel = LVL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdStrobe;
      if (strobes.rdStrobe) begin
        unique case (strobes.rdSel)
          REG_PEND:  rdData <= DATA_W'(pendQ);
          REG_MASK:  rdData <= DATA_W'(maskQ);
          REG_FORCE: rdData <= DATA_W'(forceQ);
          default:   rdData <= '0;
        endcase
      end
    end
  end

  // R3: an event pulse leaves its level pending on the next edge
  assert_uart_a_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    uartAEvt |=> pendQ[UART_A_LVL]);
  assert_rtc_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    rtcTick |=> pendQ[RTC_LVL]);

  // R4: cleared bits with no racing source are gone after the write
  assert_clear_drops_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrClear && ((srcVec & wrBits) == '0)) |=>
      ((pendQ & $past(wrBits)) == '0));

  // R8: an acknowledge retires both pending and force for that level
  assert_ack_retires_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ackStrobe && !srcVec[ackLevel] && !strobes.wrForce) |=>
      (!pendQ[$past(ackLevel)] && !forceQ[$past(ackLevel)]));

  // R6: a requested level is never a masked one
  assert_req_unmasked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != '0) |-> (!maskQ[irqLevel] &&
                          (pendQ[irqLevel] || forceQ[irqLevel])));

  // R2: the clear register always reads back zero
  assert_clear_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStrobe && strobes.rdSel == REG_CLR) |=> (rdData == '0));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int unsigned NUM_LEVELS   = 15,
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned LVL_W        = $clog2(NUM_LEVELS + 1),
  parameter int unsigned UART_A_LVL   = 4,
  parameter int unsigned UART_B_LVL   = 5,
  parameter int unsigned UART_ERR_LVL = 3,
  parameter int unsigned GPT_LVL      = 12,
  parameter int unsigned RTC_LVL      = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_IDX_W-1:0] regIdx,
  input  logic                 wrEn,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 rdEn,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  input  logic                 uartAEvt,
  input  logic                 uartBEvt,
  input  logic                 uartOvfEvt,
  input  logic                 gptTick,
  input  logic                 rtcTick,
  output logic [LVL_W-1:0]     irqLevel,
  input  logic                 ackValid,
  input  logic [LVL_W-1:0]     ackLevel
);
  ctlStrobe_t strobes;

  lvl_irq_ctl #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) ctl_i (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .wrEn(wrEn), .rdEn(rdEn),
    .ackValid(ackValid), .ackLevel(ackLevel), .strobes(strobes)
  );

  lvl_irq_dp #(
    .NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W), .LVL_W(LVL_W),
    .UART_A_LVL(UART_A_LVL), .UART_B_LVL(UART_B_LVL),
    .UART_ERR_LVL(UART_ERR_LVL), .GPT_LVL(GPT_LVL), .RTC_LVL(RTC_LVL)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .ackLevel(ackLevel), .uartAEvt(uartAEvt), .uartBEvt(uartBEvt),
    .uartOvfEvt(uartOvfEvt), .gptTick(gptTick), .rtcTick(rtcTick),
    .rdData(rdData), .rdValid(rdValid), .irqLevel(irqLevel)
  );
endmodule

// File: tb/lvl_irq_ctrl_tb_top.sv
module lvl_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regIdx = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rdValid;
  logic        uartAEvt = 0, uartBEvt = 0, uartOvfEvt = 0, gptTick = 0, rtcTick = 0;
  logic [3:0]  irqLevel;
  logic        ackValid = 1'b0;
  logic [3:0]  ackLevel = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  lvl_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .uartAEvt(uartAEvt), .uartBEvt(uartBEvt), .uartOvfEvt(uartOvfEvt),
    .gptTick(gptTick), .rtcTick(rtcTick), .irqLevel(irqLevel),
    .ackValid(ackValid), .ackLevel(ackLevel)
  );

  // src bits: {rtc, gpt, overrun, chanB, chanA}
  task automatic cycle(input bit doWr, input logic [1:0] idx, input logic [15:0] d,
                       input bit doAck, input logic [3:0] lvl, input logic [4:0] src);
    @(negedge clk);
    wrEn = doWr; regIdx = idx; wrData = d;
    ackValid = doAck; ackLevel = lvl;
    {rtcTick, gptTick, uartOvfEvt, uartBEvt, uartAEvt} = src;
    @(negedge clk);
    wrEn = 0; ackValid = 0;
    {rtcTick, gptTick, uartOvfEvt, uartBEvt, uartAEvt} = '0;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [15:0] d);
    cycle(1, idx, d, 0, 4'd0, 5'd0);
  endtask

  task automatic rd(input logic [1:0] idx, input logic [15:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1; regIdx = idx;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic chkLevel(input logic [3:0] exp, input string tag);
    checks++;
    if (irqLevel !== exp) begin
      fails++;
      $display("FAIL %s irqLevel actual=%0d expected=%0d", tag, irqLevel, exp);
    end
  endtask

  // scoreboard monitor: each valid read result is matched to the queued expectation
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL unexpected read actual=%h expected=none", rdData);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (rdData !== e) begin
          fails++;
          $display("FAIL %s rdData actual=%h expected=%h", t, rdData, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chkLevel(0, "R1 reset level");
    rd(0, 16'h0000, "R1 pending");
    rd(1, 16'hFFFE, "R1 mask");
    rd(3, 16'h0000, "R1 force");
    // R3 channel A lands on level 4; R6 still masked
    cycle(0, 0, 0, 0, 0, 5'b00001);
    rd(0, 16'h0010, "R3 chanA level 4");
    chkLevel(0, "R6 masked after reset");
    wr(1, 16'h0000);
    chkLevel(4, "R7 single level");
    // R3 remaining sources together
    cycle(0, 0, 0, 0, 0, 5'b11110);
    rd(0, 16'h3038, "R3 all sources");
    chkLevel(13, "R7 highest of several");
    // R2 pending read-only, clear reads zero
    wr(0, 16'hFFFF);
    rd(0, 16'h3038, "R2 pending ignores write");
    wr(2, 16'h0000);
    rd(0, 16'h3038, "R4 clear zero no effect");
    rd(2, 16'h0000, "R2 clear reads zero");
    // R4 clear one bit
    wr(2, 16'h2000);
    rd(0, 16'h1038, "R4 clear level 13");
    chkLevel(12, "R4 next level after clear");
    // R6 masking
    wr(1, 16'h1000);
    chkLevel(5, "R6 mask level 12");
    // R5 force
    wr(3, 16'h8002);
    rd(3, 16'h8002, "R5 force readback");
    chkLevel(15, "R5 forced level 15");
    // R8 acknowledge
    cycle(0, 0, 0, 1, 4'd15, 5'd0);
    rd(3, 16'h0002, "R8 force bit retired");
    chkLevel(5, "R8 after ack 15");
    cycle(0, 0, 0, 1, 4'd5, 5'd0);
    rd(0, 16'h1018, "R8 pending bit retired");
    chkLevel(4, "R8 after ack 5");
    // R9 source beats clear and acknowledge
    cycle(1, 2, 16'h0010, 0, 0, 5'b00001);
    rd(0, 16'h1018, "R9 source beats clear");
    cycle(0, 0, 0, 1, 4'd4, 5'b00001);
    rd(0, 16'h1018, "R9 source beats ack");
    chkLevel(4, "R9 level kept");
    // R2 bit 0 dropped
    wr(3, 16'hFFFF);
    rd(3, 16'hFFFE, "R2 force bit0 dropped");
    chkLevel(15, "R5 all forced");
    // R7 none pending
    wr(3, 16'h0000);
    wr(2, 16'hFFFF);
    rd(0, 16'h0000, "R4 clear all");
    chkLevel(0, "R7 none pending");
    // R5 lowest level by software only
    wr(1, 16'hFFFC);
    wr(3, 16'h0002);
    chkLevel(1, "R5 level 1 forced");
    wr(1, 16'hFFFE);
    chkLevel(0, "R6 level 1 masked");
    rd(1, 16'hFFFE, "R2 mask readback");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard actual=%0d pending expected=0", expQ.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule